// File: doc/BRIEF.md
# Register-Controlled Shift and Rotate Unit

This block is the shift datapath of a small RISC integer core. Each strobe it takes one operand, a second register whose value sets the shift count and direction, a 5-bit operation select and the current carry flag (T). It returns the shifted or rotated word and the new T flag. Both are registered, and a done pulse marks them one cycle after the strobe.

It covers four families of operation. The single-bit shifts load the bit that leaves the word into T. The rotates either loop the leaving bit back into the word or pass it through T. The fixed shifts by 2, 8 and 16 do not touch T. The dynamic shifts take their direction from the sign of the amount register. A non-negative amount shifts left by its low bits. A negative amount shifts right by the two's-complement magnitude of its low bits, and a negative amount whose low bits are all zero gives a shift of the full word width.

Top module: `shift_unit`

## Requirements
- R1: `done` is high in exactly the cycle after a cycle with `op_valid` high, and low after any cycle with `op_valid` low.
- R2: While `rst` is high and after it falls, before any strobe, `done`, `result` and `t_out` are all zero.
- R3: Opcodes 0 (logical left by one) and 2 (arithmetic left by one) return operand<<1 with zero in bit 0, and load T from operand bit 31.
- R4: Opcode 1 (logical right by one) fills bit 31 with zero. Opcode 3 (arithmetic right by one) keeps bit 31. Both load T from operand bit 0.
- R5: Opcode 4 (rotate left) sends operand bit 31 to both T and result bit 0. Opcode 5 (rotate right) sends operand bit 0 to both T and result bit 31.
- R6: Opcode 6 (rotate left through T) puts the old T into bit 0 and old bit 31 into T. Opcode 7 (rotate right through T) puts the old T into bit 31 and old bit 0 into T.
- R7: Opcodes 8/9 shift left/right by 2, 10/11 by 8 and 12/13 by 16, all with zero fill, and `t_out` equals `t_in`.
- R8: Opcodes 14 (arithmetic dynamic) and 15 (logical dynamic), with amount bit 31 clear, shift left by amount[4:0] and ignore amount bits 30..5. T is unchanged.
- R9: With amount bit 31 set and amount[4:0] nonzero, opcodes 14 and 15 shift right by (~amount[4:0])+1. Opcode 14 fills with the sign bit and opcode 15 fills with zero. T is unchanged.
- R10: With amount bit 31 set and amount[4:0] zero, opcode 14 returns 32 copies of the operand sign bit and opcode 15 returns zero.
- R11: Opcodes 16 to 31 return the operand unchanged with `t_out` equal to `t_in`.
- R12: In a cycle without a strobe, `result` and `t_out` keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Strobe: accept one operation this cycle |
| op_sel | input | 5 | Operation select (encodings in R3 to R11) |
| operand | input | 32 | Word to shift or rotate |
| amount | input | 32 | Dynamic shift amount register (sign sets direction) |
| t_in | input | 1 | Current T flag |
| done | output | 1 | One-cycle pulse: result and t_out are new |
| result | output | 32 | Registered result |
| t_out | output | 1 | Registered updated T flag |

## Verification
A wrong stage in the dynamic barrel would show as a misplaced bit group in `result` on the cycle right after the strobe, but only for amounts that use that stage. The vectors therefore exercise small, large and wrap-around counts in both directions. A T path wired to the wrong bit would show the same cycle in `t_out`. A broken enable on the output registers would show as `result` changing during idle cycles, which the hold checks watch for.

// File: rtl/shift_pkg.sv
package shift_pkg;

  typedef enum logic [4:0] {
    OP_LSL1  = 5'd0,
    OP_LSR1  = 5'd1,
    OP_ASL1  = 5'd2,
    OP_ASR1  = 5'd3,
    OP_ROL   = 5'd4,
    OP_ROR   = 5'd5,
    OP_RCL   = 5'd6,
    OP_RCR   = 5'd7,
    OP_LSL2  = 5'd8,
    OP_LSR2  = 5'd9,
    OP_LSL8  = 5'd10,
    OP_LSR8  = 5'd11,
    OP_LSL16 = 5'd12,
    OP_LSR16 = 5'd13,
    OP_DYNA  = 5'd14,
    OP_DYNL  = 5'd15
  } shift_op_e;

  localparam int OP_W = 5;

endpackage

// File: rtl/shift_onebit.sv
module shift_onebit #(
  parameter int W = 32
) (
  input  logic [2:0]   sel,
  input  logic [W-1:0] opnd,
  input  logic         t_in,
  output logic [W-1:0] res,
  output logic         t_new
);

  logic msb, lsb;
  assign msb = opnd[W-1];
  assign lsb = opnd[0];

  always_comb begin
    res   = opnd;
    t_new = t_in;
    case (sel)
      3'd0, 3'd2: begin res = {opnd[W-2:0], 1'b0}; t_new = msb; end
      3'd1:       begin res = {1'b0, opnd[W-1:1]}; t_new = lsb; end
      3'd3:       begin res = {msb, opnd[W-1:1]};  t_new = lsb; end
      3'd4:       begin res = {opnd[W-2:0], msb};  t_new = msb; end
      3'd5:       begin res = {lsb, opnd[W-1:1]};  t_new = lsb; end
      3'd6:       begin res = {opnd[W-2:0], t_in}; t_new = msb; end
      default:    begin res = {t_in, opnd[W-1:1]}; t_new = lsb; end
    endcase
  end

endmodule

// File: rtl/shift_fixed.sv
module shift_fixed #(
  parameter int W    = 32,
  parameter int STEP0 = 2,
  parameter int STEP1 = 8,
  parameter int STEP2 = 16
) (
  input  logic [2:0]   sel,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] res
);

  localparam int NSTEP = 3;
  localparam int STEPS [NSTEP] = '{STEP0, STEP1, STEP2};

  logic [W-1:0] cand [2*NSTEP];

  for (genvar g = 0; g < NSTEP; g++) begin : g_step
    assign cand[2*g]   = opnd << STEPS[g];
    assign cand[2*g+1] = opnd >> STEPS[g];
  end

  always_comb begin
    res = opnd;
    if (int'(sel) < 2*NSTEP) res = cand[sel];
  end

endmodule

// File: rtl/shift_dyn.sv
module shift_dyn #(
  parameter int W = 32
) (
  input  logic         arith,
  input  logic [W-1:0] opnd,
  input  logic [W-1:0] amt,
  output logic [W-1:0] res
);

  localparam int SH_W  = $clog2(W);
  localparam int CNT_W = SH_W + 1;

  logic [SH_W-1:0]  amt_lo;
  logic [CNT_W-1:0] rcnt;
  logic             fill;
  logic [W-1:0]     lchain [SH_W+1];
  logic [W-1:0]     rchain [CNT_W+1];

  assign amt_lo = amt[SH_W-1:0];
  assign rcnt   = {1'b0, ~amt_lo} + CNT_W'(1);
  assign fill   = arith & opnd[W-1];

  assign lchain[0] = opnd;
  for (genvar k = 0; k < SH_W; k++) begin : g_left
    assign lchain[k+1] = amt_lo[k] ? (lchain[k] << (1 << k)) : lchain[k];
  end

  assign rchain[0] = opnd;
  for (genvar k = 0; k < CNT_W; k++) begin : g_right
    if ((1 << k) < W) begin : g_part
      assign rchain[k+1] = rcnt[k] ? {{(1 << k){fill}}, rchain[k][W-1:(1 << k)]} : rchain[k];
    end else begin : g_full
      assign rchain[k+1] = rcnt[k] ? {W{fill}} : rchain[k];
    end
  end

  assign res = amt[W-1] ? rchain[CNT_W] : lchain[SH_W];

endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_sel,
  input  logic [W-1:0]    operand,
  input  logic [W-1:0]    amount,
  input  logic            t_in,
  output logic            done,
  output logic [W-1:0]    result,
  output logic            t_out
);

  logic [W-1:0] one_res, fix_res, dyn_res;
  logic         one_t;
  logic [W-1:0] nxt_res;
  logic         nxt_t;
  logic         is_unused, is_onebit, is_dyn;

  assign is_unused = op_sel[OP_W-1];
  assign is_onebit = !is_unused && !op_sel[3];
  assign is_dyn    = !is_unused && (op_sel[3:1] == 3'b111);

  shift_onebit #(.W(W)) u_onebit (
    .sel(op_sel[2:0]), .opnd(operand), .t_in(t_in), .res(one_res), .t_new(one_t)
  );

  shift_fixed #(.W(W)) u_fixed (
    .sel(op_sel[2:0]), .opnd(operand), .res(fix_res)
  );

  shift_dyn #(.W(W)) u_dyn (
    .arith(!op_sel[0]), .opnd(operand), .amt(amount), .res(dyn_res)
  );

  always_comb begin
    nxt_res = operand;
    nxt_t   = t_in;
    if (is_onebit) begin
      nxt_res = one_res;
      nxt_t   = one_t;
    end else if (is_dyn) begin
      nxt_res = dyn_res;
    end else if (!is_unused) begin
      nxt_res = fix_res;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      result <= '0;
      t_out  <= 1'b0;
    end else begin
      done <= op_valid;
      if (op_valid) begin
        result <= nxt_res;
        t_out  <= nxt_t;
      end
    end
  end

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_done_follows_R1: assert property (@(posedge clk) disable iff (rst)
    (past_ok && op_valid) |=> done);
  assert_no_spurious_done_R1: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !op_valid) |=> !done);
  assert_rotate_loop_R5: assert property (@(posedge clk) disable iff (rst)
    (past_ok && op_valid && op_sel == OP_ROL) |=> (result[0] == t_out));
  assert_fixed_keeps_t_R7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && op_valid && !op_sel[4] && op_sel[3] && op_sel[3:1] != 3'b111)
      |=> (t_out == $past(t_in)));
  assert_neg_zero_logical_R10: assert property (@(posedge clk) disable iff (rst)
    (past_ok && op_valid && op_sel == OP_DYNL && amount[W-1] && amount[4:0] == 5'd0)
      |=> (result == '0));
  assert_unused_pass_R11: assert property (@(posedge clk) disable iff (rst)
    (past_ok && op_valid && op_sel[4])
      |=> (result == $past(operand) && t_out == $past(t_in)));
  assert_hold_idle_R12: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !op_valid) |=> ($stable(result) && $stable(t_out)));

endmodule

// File: tb/shift_unit_tb.sv
`timescale 1ns/1ps
module shift_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [4:0]  op_sel;
  logic [31:0] operand, amount;
  logic        t_in;
  logic        done;
  logic [31:0] result;
  logic        t_out;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  shift_unit u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .operand(operand), .amount(amount), .t_in(t_in),
    .done(done), .result(result), .t_out(t_out)
  );

  // {req, op, operand, amount, t_in, exp_result, exp_t}
  localparam int NV = 26;
  localparam logic [106:0] VEC [NV] = '{
    {4'd3,  5'd0,  32'h8000_0001, 32'h0, 1'b0, 32'h0000_0002, 1'b1}, // R3
    {4'd3,  5'd2,  32'h4000_0000, 32'h0, 1'b1, 32'h8000_0000, 1'b0}, // R3
    {4'd4,  5'd1,  32'h8000_0001, 32'h0, 1'b0, 32'h4000_0000, 1'b1}, // R4
    {4'd4,  5'd3,  32'h8000_0002, 32'h0, 1'b1, 32'hC000_0001, 1'b0}, // R4
    {4'd5,  5'd4,  32'h8000_0002, 32'h0, 1'b0, 32'h0000_0005, 1'b1}, // R5
    {4'd5,  5'd5,  32'h0000_0003, 32'h0, 1'b0, 32'h8000_0001, 1'b1}, // R5
    {4'd6,  5'd6,  32'h8000_0000, 32'h0, 1'b1, 32'h0000_0001, 1'b1}, // R6
    {4'd6,  5'd7,  32'h0000_0002, 32'h0, 1'b1, 32'h8000_0001, 1'b0}, // R6
    {4'd7,  5'd8,  32'hC000_0003, 32'h0, 1'b1, 32'h0000_000C, 1'b1}, // R7
    {4'd7,  5'd9,  32'hC000_0003, 32'h0, 1'b0, 32'h3000_0000, 1'b0}, // R7
    {4'd7,  5'd10, 32'h1234_5678, 32'h0, 1'b1, 32'h3456_7800, 1'b1}, // R7
    {4'd7,  5'd11, 32'h1234_5678, 32'h0, 1'b0, 32'h0012_3456, 1'b0}, // R7
    {4'd7,  5'd12, 32'h1234_5678, 32'h0, 1'b1, 32'h5678_0000, 1'b1}, // R7
    {4'd7,  5'd13, 32'h8765_4321, 32'h0, 1'b0, 32'h0000_8765, 1'b0}, // R7
    {4'd8,  5'd14, 32'h0000_00F1, 32'h0000_0004, 1'b1, 32'h0000_0F10, 1'b1}, // R8
    {4'd8,  5'd15, 32'h8000_0001, 32'h0000_001F, 1'b0, 32'h8000_0000, 1'b0}, // R8
    {4'd8,  5'd15, 32'h0000_0001, 32'h0000_0101, 1'b1, 32'h0000_0002, 1'b1}, // R8
    {4'd9,  5'd14, 32'h8000_0000, 32'hFFFF_FFFC, 1'b0, 32'hF800_0000, 1'b0}, // R9
    {4'd9,  5'd15, 32'h8000_0000, 32'hFFFF_FFFC, 1'b1, 32'h0800_0000, 1'b1}, // R9
    {4'd9,  5'd14, 32'h8000_0000, 32'hFFFF_FFE1, 1'b0, 32'hFFFF_FFFF, 1'b0}, // R9
    {4'd9,  5'd15, 32'h8000_0000, 32'hFFFF_FFE1, 1'b1, 32'h0000_0001, 1'b1}, // R9
    {4'd10, 5'd14, 32'h8000_1234, 32'h8000_0000, 1'b1, 32'hFFFF_FFFF, 1'b1}, // R10
    {4'd10, 5'd14, 32'h7FFF_FFFF, 32'hFFFF_FFE0, 1'b0, 32'h0000_0000, 1'b0}, // R10
    {4'd10, 5'd15, 32'hFFFF_FFFF, 32'h8000_0000, 1'b1, 32'h0000_0000, 1'b1}, // R10
    {4'd11, 5'd16, 32'hDEAD_BEEF, 32'h1234_5678, 1'b1, 32'hDEAD_BEEF, 1'b1}, // R11
    {4'd11, 5'd31, 32'h0123_4567, 32'h8000_0000, 1'b0, 32'h0123_4567, 1'b0}  // R11
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [4:0] op, input logic [31:0] a, input logic [31:0] amt,
                        input logic t);
    @(negedge clk);
    op_valid = 1'b1; op_sel = op; operand = a; amount = amt; t_in = t;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst = 1'b1; op_valid = 1'b0; op_sel = '0; operand = '0; amount = '0; t_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 done in reset", {31'd0, done}, 32'd0);
    check("R2 result in reset", result, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 done after reset", {31'd0, done}, 32'd0);
    check("R2 t_out after reset", {31'd0, t_out}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [106:0] v;
      string tag;
      v = VEC[i];
      strobe(v[102:98], v[97:66], v[65:34], v[33]);
      tag = $sformatf("R%0d vector %0d", v[106:103], i);
      check({tag, " result"}, result, v[32:1]);
      check({tag, " t"}, {31'd0, t_out}, {31'd0, v[0]});
      check({"R1 done ", tag}, {31'd0, done}, 32'd1);
    end

    // R1: no done in the cycle after an idle cycle
    @(negedge clk);
    check("R1 done idle", {31'd0, done}, 32'd0);

    // R12: idle inputs toggling must not move outputs
    strobe(5'd4, 32'h8000_0002, 32'h0, 1'b0);
    op_sel = 5'd0; operand = 32'hFFFF_FFFF; amount = 32'h5; t_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 hold result", result, 32'h0000_0005);
    check("R12 hold t", {31'd0, t_out}, 32'd1);

    // R1: back-to-back strobes
    @(negedge clk);
    op_valid = 1'b1; op_sel = 5'd8; operand = 32'h1; t_in = 1'b0;
    @(negedge clk);
    check("R1 b2b first", result, 32'h4);
    op_sel = 5'd10; operand = 32'h1; t_in = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    check("R1 b2b second", result, 32'h100);
    check("R7 b2b t", {31'd0, t_out}, 32'd1);
    check("R1 b2b done", {31'd0, done}, 32'd1);

    // R2: reset after activity clears outputs
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R2 reset clears result", result, 32'd0);
    check("R2 reset clears t", {31'd0, t_out}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule